// File: doc/BRIEF.md
# Zero-Crossing Bitstream Generator

This block turns one modulation period of a sampled switching function into a parallel word for a high-speed serializer. The period is divided into `N_SLOTS` discrete time slots. Each slot becomes one bit of the output word, so an output transition can only fall on a slot boundary. The block does not fill the slots one by one. It finds the single sign change of the function inside the window with a binary search over the slot grid. Every slot before the change is then given the leading level and every slot from the change onward the opposite level.

The function is not evaluated here. For each probe the block issues a slot index on a valid/ready request channel. It then takes one sign bit back on a valid/ready response channel, where `resp_nonneg` = 1 means the function is zero or positive at that slot. A search is started with a plain `start` pulse and an `edge_rise` input. `edge_rise` = 1 describes a window where the function goes from negative to non-negative, so the leading level is 0. `edge_rise` = 0 describes a falling window, so the leading level is 1. Slot 0 is taken to lie on the leading side and is never probed.

Back-pressure works as follows. `probe_idx` is held stable while `probe_valid` waits for `probe_ready`. A response is only taken in a cycle where `resp_ready` is high. The result word is held stable on `word_data` until `word_ready` accepts it. No new search starts before the word has been taken.

Top module: `zcb_bitstream_gen`

## Requirements
- R1: After reset, `probe_valid`, `resp_ready`, `word_valid`, `done` and `busy` are all low.
- R2: `start` is acted on only while `busy` is low. A `start` pulse, with any `edge_rise`, during a running search or while a word waits has no effect on the word produced.
- R3: Every search makes exactly log2(`N_SLOTS`) probes. The first probe is at slot `N_SLOTS`/2, and slot 0 is never probed.
- R4: A probe reply counts as "past the zero" when `resp_nonneg` equals the captured `edge_rise`. The search then keeps the lower half of the window; otherwise it keeps the upper half.
- R5: Bit k of `word_data` stands for slot k, with slot 0 at the LSB. Bits below the located edge slot b hold the leading level (0 if `edge_rise` = 1, 1 if `edge_rise` = 0). Bits k >= b hold the opposite level.
- R6: If no probed slot lies past the zero, the whole word carries the leading level: all zeros for a rising window, all ones for a falling window.
- R7: If the edge lies at slot 1, only bit 0 carries the leading level.
- R8: `probe_idx` stays stable while `probe_valid` is high and `probe_ready` is low. `resp_valid` is ignored while `resp_ready` is low. No more than one of `probe_valid`, `resp_ready` and `word_valid` is high at a time.
- R9: While `word_valid` is high and `word_ready` is low, `word_data` is held. `busy` stays high until the word is accepted.
- R10: `done` is a one-cycle pulse in the first cycle of `word_valid` for each word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a search (taken only when idle) |
| edge_rise | input | 1 | 1: rising window (leading level 0); 0: falling window |
| busy | output | 1 | A search or an unaccepted word is in progress |
| probe_valid | output | 1 | Probe request valid |
| probe_ready | input | 1 | Evaluator accepts the probe |
| probe_idx | output | log2(N_SLOTS) | Slot index to evaluate |
| resp_valid | input | 1 | Evaluator reply valid |
| resp_ready | output | 1 | Block waits for a reply |
| resp_nonneg | input | 1 | Sign of the function at the probed slot (1 = zero or positive) |
| word_valid | output | 1 | Result word valid |
| word_ready | input | 1 | Serializer takes the word |
| word_data | output | N_SLOTS | One bit per slot, slot 0 at LSB |
| done | output | 1 | One-cycle pulse when a word is first presented |

## Verification
The assertions assume that the function is monotone in sign across the window, with at most one change. They also assume that the evaluator answers each accepted probe exactly once. The checks on the first word bit further rely on `edge_rise` matching the sign at slot 0. The bench models a function with one edge at a chosen slot b from 1 to `N_SLOTS`. It derives every reply from that single edge and the window polarity, so the stimulus always meets these assumptions. It still drives random `resp_valid` and sign values whenever `resp_ready` is low, and it applies random `probe_ready` and `word_ready` back-pressure.

// File: rtl/zcb_pkg.sv
package zcb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_OUT
  } zcb_state_e;
endpackage

// File: rtl/zcb_search.sv
module zcb_search
  import zcb_pkg::*;
#(
  parameter int N_SLOTS = 16,
  localparam int CW = $clog2(N_SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          edge_rise,
  input  logic          probe_ready,
  input  logic          resp_valid,
  input  logic          resp_nonneg,
  input  logic          word_ready,
  output logic          busy,
  output logic          probe_valid,
  output logic [CW-1:0] probe_idx,
  output logic          resp_ready,
  output logic          word_valid,
  output logic          done,
  output logic          rise_q,
  output logic [CW:0]   edge_pos
);
  localparam logic [CW-1:0] HALF = CW'(N_SLOTS / 2);

  zcb_state_e    state;
  logic [CW-1:0] base;   // last slot known to sit before the zero
  logic [CW-1:0] step;   // one-hot half-width of the remaining window
  logic          crossed;

  assign crossed = (resp_nonneg == rise_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      base   <= '0;
      step   <= '0;
      rise_q <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          rise_q <= edge_rise;
          base   <= '0;
          step   <= HALF;
          state  <= ST_REQ;
        end
        ST_REQ: if (probe_ready) state <= ST_WAIT;
        ST_WAIT: if (resp_valid) begin
          if (!crossed) base <= base + step;
          if (step == CW'(1)) begin
            state <= ST_OUT;
            done  <= 1'b1;
          end else begin
            step  <= step >> 1;
            state <= ST_REQ;
          end
        end
        ST_OUT: if (word_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy        = (state != ST_IDLE);
  assign probe_valid = (state == ST_REQ);
  assign resp_ready  = (state == ST_WAIT);
  assign word_valid  = (state == ST_OUT);
  assign probe_idx   = base + step;
  assign edge_pos    = {1'b0, base} + (CW + 1)'(1);
endmodule

// File: rtl/zcb_fill.sv
module zcb_fill #(
  parameter int N_SLOTS = 16,
  localparam int CW = $clog2(N_SLOTS)
) (
  input  logic [CW:0]        edge_pos,
  input  logic               rise,
  output logic [N_SLOTS-1:0] word
);
  for (genvar k = 0; k < N_SLOTS; k++) begin : g_slot
    assign word[k] = ((CW + 1)'(k) >= edge_pos) ? rise : ~rise;
  end
endmodule

// File: rtl/zcb_bitstream_gen.sv
module zcb_bitstream_gen #(
  parameter int N_SLOTS = 16,
  localparam int CW = $clog2(N_SLOTS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               edge_rise,
  output logic               busy,
  output logic               probe_valid,
  input  logic               probe_ready,
  output logic [CW-1:0]      probe_idx,
  input  logic               resp_valid,
  output logic               resp_ready,
  input  logic               resp_nonneg,
  output logic               word_valid,
  input  logic               word_ready,
  output logic [N_SLOTS-1:0] word_data,
  output logic               done
);
  logic          rise_q;
  logic [CW:0]   edge_pos;

  zcb_search #(.N_SLOTS(N_SLOTS)) u_search (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .edge_rise   (edge_rise),
    .probe_ready (probe_ready),
    .resp_valid  (resp_valid),
    .resp_nonneg (resp_nonneg),
    .word_ready  (word_ready),
    .busy        (busy),
    .probe_valid (probe_valid),
    .probe_idx   (probe_idx),
    .resp_ready  (resp_ready),
    .word_valid  (word_valid),
    .done        (done),
    .rise_q      (rise_q),
    .edge_pos    (edge_pos)
  );

  zcb_fill #(.N_SLOTS(N_SLOTS)) u_fill (
    .edge_pos (edge_pos),
    .rise     (rise_q),
    .word     (word_data)
  );
endmodule

// File: rtl/zcb_checker.sv
module zcb_checker #(
  parameter int N_SLOTS = 16,
  localparam int CW = $clog2(N_SLOTS)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic               edge_rise,
  input logic               busy,
  input logic               probe_valid,
  input logic               probe_ready,
  input logic [CW-1:0]      probe_idx,
  input logic               resp_ready,
  input logic               word_valid,
  input logic               word_ready,
  input logic [N_SLOTS-1:0] word_data,
  input logic               done
);
  logic rise_cap;

  always_ff @(posedge clk) begin
    if (!rst_n) rise_cap <= 1'b0;
    else if (start && !busy) rise_cap <= edge_rise;
  end

  AST_FIRST_PROBE_MID: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> probe_valid && probe_idx == CW'(N_SLOTS / 2)); // R3
  AST_NO_SLOT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    probe_valid |-> probe_idx != '0); // R3
  AST_PROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    probe_valid && !probe_ready |=> probe_valid && $stable(probe_idx)); // R8
  AST_CHANNEL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({probe_valid, resp_ready, word_valid})); // R8
  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid && !word_ready |=> word_valid && $stable(word_data) && busy); // R9
  AST_DONE_WITH_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> word_valid); // R10
  AST_DONE_ON_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid && !$past(word_valid) |-> done); // R10
  AST_LEAD_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> word_data[0] == !rise_cap); // R5
  AST_SINGLE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> $countones(word_data[N_SLOTS-1:1] ^ word_data[N_SLOTS-2:0]) <= 1); // R5
endmodule

bind zcb_bitstream_gen zcb_checker #(.N_SLOTS(N_SLOTS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .edge_rise   (edge_rise),
  .busy        (busy),
  .probe_valid (probe_valid),
  .probe_ready (probe_ready),
  .probe_idx   (probe_idx),
  .resp_ready  (resp_ready),
  .word_valid  (word_valid),
  .word_ready  (word_ready),
  .word_data   (word_data),
  .done        (done)
);

// File: tb/zcb_bitstream_gen_tb.sv
module zcb_bitstream_gen_tb;
  localparam int N = 16;
  localparam int CW = $clog2(N);
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, edge_rise = 1'b0;
  logic probe_ready = 1'b0, resp_valid = 1'b0, resp_nonneg = 1'b0, word_ready = 1'b0;
  logic busy, probe_valid, resp_ready, word_valid, done;
  logic [CW-1:0] probe_idx;
  logic [N-1:0]  word_data;

  always #(CLK_PERIOD / 2) clk = ~clk;

  zcb_bitstream_gen #(.N_SLOTS(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .edge_rise(edge_rise), .busy(busy),
    .probe_valid(probe_valid), .probe_ready(probe_ready), .probe_idx(probe_idx),
    .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_nonneg(resp_nonneg),
    .word_valid(word_valid), .word_ready(word_ready), .word_data(word_data), .done(done)
  );

  int checks = 0, errors = 0;
  logic [N-1:0] exp_q[$];
  string        tag_q[$];
  int probe_cnt = 0, first_idx = 0, completed = 0, cur_b = N;
  logic cur_rise = 1'b0, bp_en = 1'b0, pend = 1'b0, prev_wv = 1'b0;
  logic [CW-1:0] pend_idx = '0;
  logic [N-1:0]  prev_wd = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Evaluator model and scoreboard monitor, all on the falling edge.
  always @(negedge clk) if (rst_n) begin
    if (probe_valid) begin
      probe_ready = ($urandom_range(0, 2) != 0);
      if (probe_ready) begin
        if (probe_cnt == 0) first_idx = int'(probe_idx);
        chk(probe_idx != '0, "R3", "probe at slot 0", 64'(probe_idx), 64'(1));
        probe_cnt++;
        pend = 1'b1;
        pend_idx = probe_idx;
      end
    end else probe_ready = 1'b0;

    if (resp_ready) begin
      if (pend && ($urandom_range(0, 1) != 0)) begin
        resp_valid  = 1'b1;
        resp_nonneg = (int'(pend_idx) >= cur_b) ? cur_rise : !cur_rise; // R4 sign model
        pend = 1'b0;
      end else resp_valid = 1'b0;
    end else begin
      // R8: garbage replies while not ready must be ignored
      resp_valid  = ($urandom_range(0, 1) != 0);
      resp_nonneg = ($urandom_range(0, 1) != 0);
    end

    if (word_valid) begin
      if (!prev_wv) begin
        chk(done == 1'b1, "R10", "done on first word cycle", 64'(done), 64'(1));
        chk(probe_cnt == CW, "R3", "probe count", 64'(probe_cnt), 64'(CW));
        chk(first_idx == N / 2, "R3", "first probe slot", 64'(first_idx), 64'(N / 2));
      end else begin
        chk(done == 1'b0, "R10", "done longer than one cycle", 64'(done), 64'(0));
        chk(word_data == prev_wd, "R9", "word held under back-pressure",
            64'(word_data), 64'(prev_wd));
        chk(busy == 1'b1, "R9", "busy while word waits", 64'(busy), 64'(1));
      end
      word_ready = bp_en ? ($urandom_range(0, 3) == 0) : 1'b1;
      if (word_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R5", "unexpected word", 64'(word_data), 64'(0));
        end else begin
          logic [N-1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(word_data == e, t, "result word", 64'(word_data), 64'(e));
        end
        probe_cnt = 0;
        completed++;
      end
    end else begin
      chk(done == 1'b0, "R10", "done without word", 64'(done), 64'(0));
      word_ready = ($urandom_range(0, 1) != 0);
    end
    prev_wv = word_valid && !word_ready;
    prev_wd = word_data;
  end

  task automatic run(input int b, input logic rise, input string tag, input bit interfere);
    logic [N-1:0] e;
    int c;
    for (int k = 0; k < N; k++) e[k] = (k >= b) ? rise : !rise;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    while (busy) @(negedge clk);
    c = completed;
    cur_b = b;
    cur_rise = rise;
    start = 1'b1;
    edge_rise = rise;
    @(negedge clk);
    start = 1'b0;
    if (interfere) begin
      // R2: a start of the opposite polarity mid-search must be ignored
      repeat (3) @(negedge clk);
      start = 1'b1;
      edge_rise = !rise;
      @(negedge clk);
      start = 1'b0;
    end
    while (completed == c) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(probe_valid == 1'b0, "R1", "probe_valid in reset", 64'(probe_valid), 64'(0));
    chk(resp_ready == 1'b0, "R1", "resp_ready in reset", 64'(resp_ready), 64'(0));
    chk(word_valid == 1'b0, "R1", "word_valid in reset", 64'(word_valid), 64'(0));
    chk(done == 1'b0, "R1", "done in reset", 64'(done), 64'(0));
    chk(busy == 1'b0, "R1", "busy in reset", 64'(busy), 64'(0));
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R1", "busy after reset", 64'(busy), 64'(0));

    run(5, 1'b1, "R5", 1'b0);
    run(11, 1'b0, "R5", 1'b0);
    run(N, 1'b1, "R6", 1'b0);
    run(N, 1'b0, "R6", 1'b0);
    run(1, 1'b1, "R7", 1'b0);
    run(1, 1'b0, "R7", 1'b0);
    run(7, 1'b1, "R2", 1'b1);
    run(9, 1'b0, "R2", 1'b1);
    bp_en = 1'b1;
    for (int b = 1; b <= N; b++) begin
      run(b, 1'b1, "R4", b[0]);
      run(b, 1'b0, "R4", 1'b0);
    end
    bp_en = 1'b0;
    run(8, 1'b1, "R4", 1'b0);
    chk(exp_q.size() == 0, "R5", "words outstanding", 64'(exp_q.size()), 64'(0));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule